// File: doc/BRIEF.md
# Boot Instruction Injector

This block loads a memory image through an 8-bit processor that has no boot ROM. It owns the processor's clock and reset lines. While a load runs, it feeds the processor instructions on the data bus, so the processor itself carries every byte to its place in memory. For each byte the processor fetches an accumulator load with an immediate value, then a store of that accumulator to an absolute address. When the processor performs the store, the block lets go of the data bus so that memory takes the processor's write.

A host supplies the image as a stream of bytes. Each byte comes with its own 16-bit target address, so the targets need not be contiguous, and the last byte carries a flag. A start pulse holds the processor in reset for a fixed number of clock cycles. The block then answers the reset-vector fetch with an address of its own choosing, and serves the injected stream as the processor fetches from there. If the next byte has not arrived, the block stops the processor clock in its low phase. Once the last byte is written, the block can also inject a jump to an entry address. It then releases the bus and raises done, and the processor runs freely from that point.

Top module: `boot_injector`

## Requirements
- R1: After the block's own reset, cpu_rst_n, cpu_clk, cpu_doe, src_ready and done are all low.
- R2: A start pulse holds cpu_rst_n low for exactly RST_CYCLES high phases of cpu_clk, then releases it. While cpu_rst_n is low the block drives no data.
- R3: After reset is released, a read of address 0xFFFC returns the low byte of BOOT_PC and a read of 0xFFFD returns its high byte. Any other read before that gets 0xEA. The processor therefore starts fetching at BOOT_PC.
- R4: Each byte of the image is served as five read cycles in this order: 0xA9, the data byte, 0x8D, the target address low byte, the target address high byte.
- R5: The sixth bus cycle of each byte is the processor's write, and cpu_doe is low for that whole cycle.
- R6: After a load, memory holds every supplied byte at its own target address, including targets that are scattered and out of order.
- R7: At a byte boundary with src_valid low, cpu_clk stays low and no bus cycle runs. The load resumes when src_valid returns.
- R8: src_ready is high for one clk cycle per byte, at the end of that byte's write cycle and only while src_valid is high.
- R9: With jump_en high, the last byte is followed by read cycles serving 0x4C, entry low byte and entry high byte, so the next fetch is at entry_addr.
- R10: With jump_en low, done rises right after the last write cycle, so the next fetch is at BOOT_PC + 5 × byte count.
- R11: While done is high, cpu_rst_n is high, cpu_doe is low and cpu_clk keeps toggling. Done holds until a new start, and a new start runs a complete fresh load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load (accepted when idle or done) |
| jump_en | input | 1 | Inject a jump to entry_addr after the last byte |
| entry_addr | input | 16 | Jump target, held stable during a load |
| src_valid | input | 1 | Image byte available |
| src_ready | output | 1 | Image byte consumed |
| src_data | input | 8 | Image byte |
| src_addr | input | 16 | Target address of the image byte |
| src_last | input | 1 | Marks the final image byte |
| cpu_clk | output | 1 | Processor clock |
| cpu_rst_n | output | 1 | Processor reset, active low |
| cpu_addr | input | 16 | Processor address bus |
| cpu_rw | input | 1 | Processor read (1) / write (0) |
| cpu_dout | output | 8 | Data the block drives onto the processor bus |
| cpu_doe | output | 1 | Enable for cpu_dout |
| done | output | 1 | Load finished, bus released |

## Verification
The bench drives the block with a behavioural processor that decodes whatever it fetches and writes to a sparse memory. A wrong opcode, a swapped pair of address bytes or a missing cycle therefore shows up as bytes at the wrong place or as an illegal opcode. One load uses targets scattered across the space in descending and mixed order. Another sends bytes with long gaps. A design that kept the clock running without data would inject a stale byte, and the bench would also see cpu_clk high inside the gap. The bench counts reset-phase clock pulses and compares the reset vector the processor takes, so an off-by-one in the reset hold or a byte-swapped vector is caught. It also compares the first fetch address after done against entry_addr in jump mode, and against BOOT_PC + 5n without the jump. A design that raised done one cycle early or late, or that kept driving the bus during the processor's write, is reported.

// File: rtl/boot_inj_pkg.sv
package boot_inj_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RESET,
    ST_VECTOR,
    ST_STREAM,
    ST_JUMP,
    ST_DONE
  } inj_state_e;

  localparam logic [BYTE_W-1:0] OPC_LOAD_IMM  = 8'hA9;
  localparam logic [BYTE_W-1:0] OPC_STORE_ABS = 8'h8D;
  localparam logic [BYTE_W-1:0] OPC_JUMP_ABS  = 8'h4C;
  localparam logic [BYTE_W-1:0] OPC_FILLER    = 8'hEA;

  localparam logic [ADDR_W-1:0] VEC_LO_ADDR = 16'hFFFC;
  localparam logic [ADDR_W-1:0] VEC_HI_ADDR = 16'hFFFD;

  localparam int unsigned STEP_WRITE    = 5;
  localparam int unsigned STEP_JUMP_END = 2;
endpackage

// File: rtl/boot_inj_clkgen.sv
module boot_inj_clkgen (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic cpu_clk,
  output logic cyc_end
);
  logic phase_q;
  logic phase_d;
  logic phase_en;

  // A high phase always ends after one clk; a low phase only ends when run.
  always_comb begin
    phase_en = phase_q | run;
    phase_d  = ~phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
    end else if (phase_en) begin
      phase_q <= phase_d;
    end
  end

  assign cpu_clk = phase_q;
  assign cyc_end = phase_q;
endmodule

// File: rtl/boot_inj_seq.sv
module boot_inj_seq
  import boot_inj_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              jump_en,
  input  logic              src_valid,
  input  logic              src_last,
  input  logic              cyc_end,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rw,
  output inj_state_e        state,
  output logic [2:0]        step,
  output logic              run,
  output logic              cpu_rst_n,
  output logic              src_ready,
  output logic              done
);
  localparam int unsigned RW = $clog2(RST_CYCLES + 1);
  localparam int unsigned CW = (RW > 3) ? RW : 3;
  localparam logic [CW-1:0] RST_LAST = CW'(RST_CYCLES - 1);

  inj_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          adv_en;
  logic          at_boundary;

  assign at_boundary = (state_q == ST_STREAM) && (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          state_d = ST_RESET;
          cnt_d   = '0;
        end
      end
      ST_RESET: begin
        if (cyc_end) begin
          if (cnt_q == RST_LAST) begin
            state_d = ST_VECTOR;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_VECTOR: begin
        if (cyc_end && cpu_rw && (cpu_addr == VEC_HI_ADDR)) begin
          state_d = ST_STREAM;
          cnt_d   = '0;
        end
      end
      ST_STREAM: begin
        if (cyc_end) begin
          if (cnt_q == CW'(STEP_WRITE)) begin
            cnt_d = '0;
            if (src_last) state_d = jump_en ? ST_JUMP : ST_DONE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_JUMP: begin
        if (cyc_end) begin
          if (cnt_q == CW'(STEP_JUMP_END)) begin
            state_d = ST_DONE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  assign adv_en = cyc_end | start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (adv_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state     = state_q;
  assign step      = cnt_q[2:0];
  assign run       = (state_q != ST_IDLE) && !(at_boundary && !src_valid);
  assign cpu_rst_n = (state_q != ST_IDLE) && (state_q != ST_RESET);
  assign src_ready = (state_q == ST_STREAM) && (cnt_q == CW'(STEP_WRITE)) && cyc_end;
  assign done      = (state_q == ST_DONE);
endmodule

// File: rtl/boot_inj_mux.sv
module boot_inj_mux
  import boot_inj_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BOOT_PC = 16'h0200
) (
  input  inj_state_e        state,
  input  logic [2:0]        step,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rw,
  input  logic [BYTE_W-1:0] src_data,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] entry_addr,
  output logic [BYTE_W-1:0] dout,
  output logic              doe
);
  logic drive;

  always_comb begin
    dout  = OPC_FILLER;
    drive = 1'b0;
    unique case (state)
      ST_VECTOR: begin
        drive = 1'b1;
        if (cpu_addr == VEC_LO_ADDR)      dout = BOOT_PC[BYTE_W-1:0];
        else if (cpu_addr == VEC_HI_ADDR) dout = BOOT_PC[ADDR_W-1:BYTE_W];
      end
      ST_STREAM: begin
        drive = 1'b1;
        unique case (step)
          3'd0:    dout = OPC_LOAD_IMM;
          3'd1:    dout = src_data;
          3'd2:    dout = OPC_STORE_ABS;
          3'd3:    dout = src_addr[BYTE_W-1:0];
          3'd4:    dout = src_addr[ADDR_W-1:BYTE_W];
          default: drive = 1'b0;
        endcase
      end
      ST_JUMP: begin
        drive = 1'b1;
        unique case (step)
          3'd0:    dout = OPC_JUMP_ABS;
          3'd1:    dout = entry_addr[BYTE_W-1:0];
          default: dout = entry_addr[ADDR_W-1:BYTE_W];
        endcase
      end
      default: drive = 1'b0;
    endcase
  end

  assign doe = drive & cpu_rw;
endmodule

// File: rtl/boot_injector.sv
module boot_injector
  import boot_inj_pkg::*;
#(
  parameter int unsigned       RST_CYCLES = 6,
  parameter logic [ADDR_W-1:0] BOOT_PC    = 16'h0200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              jump_en,
  input  logic [ADDR_W-1:0] entry_addr,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [BYTE_W-1:0] src_data,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic              src_last,
  output logic              cpu_clk,
  output logic              cpu_rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rw,
  output logic [BYTE_W-1:0] cpu_dout,
  output logic              cpu_doe,
  output logic              done
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  inj_state_e state;
  logic [2:0] step;
  logic       run;
  logic       cyc_end;

  boot_inj_clkgen u_clkgen (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (run),
    .cpu_clk (cpu_clk),
    .cyc_end (cyc_end)
  );

  boot_inj_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .jump_en   (jump_en),
    .src_valid (src_valid),
    .src_last  (src_last),
    .cyc_end   (cyc_end),
    .cpu_addr  (cpu_addr),
    .cpu_rw    (cpu_rw),
    .state     (state),
    .step      (step),
    .run       (run),
    .cpu_rst_n (cpu_rst_n),
    .src_ready (src_ready),
    .done      (done)
  );

  boot_inj_mux #(.BOOT_PC(BOOT_PC)) u_mux (
    .state      (state),
    .step       (step),
    .cpu_addr   (cpu_addr),
    .cpu_rw     (cpu_rw),
    .src_data   (src_data),
    .src_addr   (src_addr),
    .entry_addr (entry_addr),
    .dout       (cpu_dout),
    .doe        (cpu_doe)
  );
endmodule

// File: rtl/boot_injector_chk.sv
module boot_injector_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic src_valid,
  input logic src_ready,
  input logic cpu_clk,
  input logic cpu_rst_n,
  input logic cpu_doe,
  input logic done
);
  AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rst_n |-> !cpu_doe); // R2

  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |=> !src_ready); // R8

  AST_READY_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> src_valid); // R8

  AST_READY_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> cpu_clk); // R8

  AST_HIGH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk |=> !cpu_clk); // R7

  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cpu_rst_n && !cpu_doe)); // R11

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R11
endmodule

bind boot_injector boot_injector_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .src_valid (src_valid),
  .src_ready (src_ready),
  .cpu_clk   (cpu_clk),
  .cpu_rst_n (cpu_rst_n),
  .cpu_doe   (cpu_doe),
  .done      (done)
);

// File: tb/boot_injector_test.sv
`timescale 1ns/1ps
module boot_injector_test;
  localparam int unsigned RSTC = 6;
  localparam logic [15:0] BOOT = 16'h0200;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        jump_en;
  logic [15:0] entry_addr;
  logic        src_valid;
  logic        src_ready;
  logic [7:0]  src_data;
  logic [15:0] src_addr;
  logic        src_last;
  logic        cpu_clk;
  logic        cpu_rst_n;
  logic [15:0] m_addr;
  logic        m_rw;
  logic [7:0]  cpu_dout;
  logic        cpu_doe;
  logic        done;

  boot_injector #(.RST_CYCLES(RSTC), .BOOT_PC(BOOT)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .jump_en(jump_en),
    .entry_addr(entry_addr), .src_valid(src_valid), .src_ready(src_ready),
    .src_data(src_data), .src_addr(src_addr), .src_last(src_last),
    .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .cpu_addr(m_addr), .cpu_rw(m_rw),
    .cpu_dout(cpu_dout), .cpu_doe(cpu_doe), .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Behavioural processor and memory
  logic [7:0]  mem [0:65535];
  logic [15:0] nx_addr, pc, ea, vec_pc, post_pc;
  logic        nx_rw;
  logic [7:0]  acc, lo, vlo, d;
  int          ms;
  int          rst_hi, illegal, contention, rdy_cnt;
  bit          halt, post_seen;

  initial begin
    m_addr = 16'h01FF; m_rw = 1'b1; nx_addr = 16'h01FF; nx_rw = 1'b1;
    ms = 0; halt = 1'b0; post_seen = 1'b0;
    rst_hi = 0; illegal = 0; contention = 0; rdy_cnt = 0;
  end

  always @(negedge clk) begin
    if (src_ready) rdy_cnt++;
    if (!cpu_clk) begin
      m_addr = nx_addr;
      m_rw   = nx_rw;
    end else if (!cpu_rst_n) begin
      rst_hi++;
      ms = 0; halt = 1'b0; nx_addr = 16'h01FF; nx_rw = 1'b1;
    end else if (!halt) begin
      d = cpu_doe ? cpu_dout : mem[m_addr];
      case (ms)
        0, 1, 2, 3: begin ms++; nx_addr = (ms == 4) ? 16'hFFFC : 16'h01FD; end
        4: begin vlo = d; nx_addr = 16'hFFFD; ms = 5; end
        5: begin pc = {d, vlo}; vec_pc = pc; nx_addr = pc; ms = 6; end
        6: begin
          if (done && !post_seen) begin
            post_pc = m_addr; post_seen = 1'b1; halt = 1'b1;
          end else begin
            pc = pc + 16'd1;
            case (d)
              8'hA9: ms = 7;
              8'h8D: ms = 8;
              8'h4C: ms = 10;
              default: illegal++;
            endcase
            nx_addr = pc;
          end
        end
        7:  begin acc = d; pc = pc + 16'd1; nx_addr = pc; ms = 6; end
        8:  begin lo = d; pc = pc + 16'd1; nx_addr = pc; ms = 9; end
        9:  begin ea = {d, lo}; pc = pc + 16'd1; nx_addr = ea; nx_rw = 1'b0; ms = 11; end
        11: begin
          if (cpu_doe) contention++;
          mem[m_addr] = acc;
          nx_addr = pc; nx_rw = 1'b1; ms = 6;
        end
        10: begin lo = d; pc = pc + 16'd1; nx_addr = pc; ms = 12; end
        12: begin pc = {d, lo}; nx_addr = pc; ms = 6; end
        default: ms = 6;
      endcase
    end
  end

  logic [7:0]  img_d [0:7];
  logic [15:0] img_a [0:7];
  int          stall_hi;

  task automatic run_load(input int n, input bit jmp, input logic [15:0] ent,
                          input int gap);
    int t;
    rst_hi = 0; illegal = 0; contention = 0; rdy_cnt = 0; stall_hi = 0;
    post_seen = 1'b0;
    for (int i = 0; i < n; i++) mem[img_a[i]] = ~img_d[i];
    @(negedge clk);
    jump_en = jmp; entry_addr = ent; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      src_valid = 1'b1; src_data = img_d[i]; src_addr = img_a[i];
      src_last = (i == n - 1);
      t = 0;
      do begin @(negedge clk); t++; end while (!src_ready && t < 5000);
      @(negedge clk);
      if (gap > 0 && i < n - 1) begin
        src_valid = 1'b0;
        for (int g = 0; g < gap; g++) begin
          if (cpu_clk) stall_hi++;
          @(negedge clk);
        end
      end
    end
    src_valid = 1'b0; src_last = 1'b0;
    t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    t = 0;
    while (!post_seen && t < 200) begin @(negedge clk); t++; end
  endtask

  task automatic check_common(input int n);
    chk(rst_hi == RSTC, "R2", "reset high phases", rst_hi, RSTC);
    chk(vec_pc == BOOT, "R3", "vector taken", vec_pc, BOOT);
    chk(illegal == 0, "R4", "illegal opcodes", illegal, 0);
    chk(contention == 0, "R5", "drive during write", contention, 0);
    for (int i = 0; i < n; i++)
      chk(mem[img_a[i]] == img_d[i], "R6", "memory byte", mem[img_a[i]], img_d[i]);
    chk(rdy_cnt == n, "R8", "ready pulses", rdy_cnt, n);
  endtask

  task automatic t_reset;
    chk(cpu_rst_n == 1'b0, "R1", "cpu_rst_n", cpu_rst_n, 0);
    chk(cpu_clk == 1'b0, "R1", "cpu_clk", cpu_clk, 0);
    chk(cpu_doe == 1'b0, "R1", "cpu_doe", cpu_doe, 0);
    chk(src_ready == 1'b0, "R1", "src_ready", src_ready, 0);
    chk(done == 1'b0, "R1", "done", done, 0);
  endtask

  task automatic t_scatter_jump;
    img_d[0] = 8'h11; img_a[0] = 16'h8001;
    img_d[1] = 8'hA9; img_a[1] = 16'h1234;
    img_d[2] = 8'h00; img_a[2] = 16'h0300;
    img_d[3] = 8'hFE; img_a[3] = 16'hC030;
    img_d[4] = 8'h8D; img_a[4] = 16'h00FF;
    run_load(5, 1'b1, 16'h4567, 0);
    check_common(5);
    chk(post_seen && post_pc == 16'h4567, "R9", "fetch after jump", post_pc, 16'h4567);
  endtask

  task automatic t_gap_nojump;
    int hi;
    img_d[0] = 8'h5A; img_a[0] = 16'h0300;
    img_d[1] = 8'hC3; img_a[1] = 16'hF840;
    img_d[2] = 8'h77; img_a[2] = 16'h0010;
    run_load(3, 1'b0, 16'h9999, 25);
    check_common(3);
    chk(stall_hi == 0, "R7", "cpu_clk high while stalled", stall_hi, 0);
    chk(post_seen && post_pc == BOOT + 16'd15, "R10", "fetch after last store",
        post_pc, BOOT + 16'd15);
    hi = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (cpu_clk) hi++;
      chk(cpu_doe == 1'b0 && cpu_rst_n == 1'b1 && done == 1'b1, "R11",
          "released while done", {cpu_doe, cpu_rst_n, done}, 3'b011);
    end
    chk(hi > 0, "R11", "clock runs while done", hi, 6);
  endtask

  task automatic t_restart;
    img_d[0] = 8'h3C; img_a[0] = 16'h0300;
    run_load(1, 1'b1, 16'h0300, 0);
    check_common(1);
    chk(post_seen && post_pc == 16'h0300, "R11", "restart then jump", post_pc, 16'h0300);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; jump_en = 1'b0; entry_addr = '0;
    src_valid = 1'b0; src_data = '0; src_addr = '0; src_last = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_scatter_jump();
    t_gap_nojump();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule